// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block connects a small 8-bit core to an external memory bus. Code fetches and data reads and writes leave the block on two ports. The low port is shared: it carries the low address byte first and the data byte afterwards. The high port is a separate port for the upper address. An address-latch strobe tells external logic when to capture the low address byte. The block keeps that strobe running at a fixed rate. A machine cycle is twelve oscillator clocks, split into two six-clock slots, and the strobe pulses at the start of every slot.

The core places one request at a time: a code fetch at a 16-bit program counter, or a data read or write. A data access uses either a 16-bit pointer or an 8-bit register address. A fetch takes one slot. A data access takes a whole machine cycle, and the strobe pulse of its second slot is left out. An external-access input chooses where code is read from. When it is low, every fetch goes to the external bus under a program-store strobe. When it is high, the fetch is served from an internal program memory interface, and no bus strobe is asserted.

Top module: `ebus_seq`

## Requirements
- R1: With no data access in progress, `ale` is high for ALE_CLKS (2) clocks at the start of every slot of SLOT_CLKS (6) clocks. This gives one pulse per six clocks.
- R2: Each data access (op 1, 2, 3 or 4) leaves out exactly one `ale` pulse, the pulse of its second slot.
- R3: During an external access, `lo_out` carries the low address byte with `lo_oe` high while `ale` is high. At all other times `lo_oe` is low, except during the write window of R4.
- R4: In a write (op 2 = 16-bit pointer, op 4 = 8-bit register), `wr_n` is low for 8 clocks. `lo_oe` is high and `lo_out` holds the write byte from the clock after `ale` falls until `wr_n` returns high.
- R5: In a read, `lo_oe` stays low. The byte on `lo_in` returns on `rsp_data` with a one-clock `rsp_valid` pulse, 11 clocks after the accepting edge for data reads and 6 clocks after it for fetches.
- R6: For code fetches (op 0) and 16-bit pointer accesses (op 1 = read, op 2 = write), `hi_out` carries the upper address byte throughout the access.
- R7: For 8-bit register accesses (op 3 = read, op 4 = write), `hi_out` carries the current `hi_sfr` value and not an address byte.
- R8: With `ea_n` high at acceptance, a fetch asserts no strobe and leaves `lo_oe` low. It returns `rom_data` for address `rom_addr`. With `ea_n` low, every address 0x0000 to 0xFFFF is fetched externally under `psen_n`.
- R9: Data accesses never assert `psen_n`. At most one of `psen_n`, `rd_n` and `wr_n` is low at any time, and none is low in reset.
- R10: `req_ready` is high only in the last clock of a slot. It is low during the first slot of a data access. A request is taken when `req_valid` and `req_ready` are both high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ea_n | input | 1 | Low: fetch from the external bus; high: fetch from internal memory |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | 0 fetch, 1 read16, 2 write16, 3 read8, 4 write8 |
| req_addr | input | ADDR_W | Program counter, pointer, or register address in the low byte |
| req_wdata | input | DATA_W | Write byte |
| req_ready | output | 1 | Request taken at this edge if valid |
| rsp_valid | output | 1 | One-clock pulse with returned byte |
| rsp_data | output | DATA_W | Fetched or read byte |
| hi_sfr | input | ADDR_W-DATA_W | Current high-port output register value |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | External code read strobe, active low |
| rd_n | output | 1 | External data read strobe, active low |
| wr_n | output | 1 | External data write strobe, active low |
| lo_out | output | DATA_W | Low port drive value |
| lo_oe | output | 1 | Low port drive enable |
| lo_in | input | DATA_W | Low port sampled value |
| hi_out | output | ADDR_W-DATA_W | High port value |
| rom_addr | output | ADDR_W | Internal program memory address |
| rom_data | input | DATA_W | Internal program memory byte |

## Verification
A request is taken on the edge that ends slot phase 5. A fetch answers 6 clocks after that edge and a data read 11 clocks after it. The bench records the cycle of each accepting edge and checks both the returned byte and that exact distance when `rsp_valid` is seen. Pin checks start at the first sample where a bus strobe is low, which is four clocks into the slot. At that sample the latched low byte and `hi_out` are compared. The strobe-suppression check counts `ale` rising edges over windows that start exactly on a slot boundary. All samples are taken one nanosecond after the falling edge.

// File: rtl/ebus_pkg.sv
`timescale 1ns/1ps
package ebus_pkg;

   typedef enum logic [2:0] {
      OP_FETCH = 3'd0,
      OP_RD16  = 3'd1,
      OP_WR16  = 3'd2,
      OP_RD8   = 3'd3,
      OP_WR8   = 3'd4
   } ebus_op_e;

   function automatic logic op_is_data(ebus_op_e o);
      return o != OP_FETCH;
   endfunction

   function automatic logic op_is_write(ebus_op_e o);
      return (o == OP_WR16) || (o == OP_WR8);
   endfunction

   function automatic logic op_is_short(ebus_op_e o);
      return (o == OP_RD8) || (o == OP_WR8);
   endfunction

endpackage

// File: rtl/ebus_slot_timer.sv
`timescale 1ns/1ps
module ebus_slot_timer #(
   parameter int SLOT_CLKS = 6,
   localparam int PW = $clog2(SLOT_CLKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [PW-1:0] phase,
   output logic          slot_end
);

   localparam logic [PW-1:0] LAST = PW'(SLOT_CLKS - 1);

   assign slot_end = (phase == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        phase <= '0;
      else if (slot_end) phase <= '0;
      else               phase <= phase + 1'b1;
   end

endmodule

// File: rtl/ebus_xfer_ctrl.sv
`timescale 1ns/1ps
module ebus_xfer_ctrl
   import ebus_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int SLOT_CLKS = 6,
   localparam int PW = $clog2(SLOT_CLKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PW-1:0]     phase,
   input  logic              slot_end,
   input  logic              ea_n,
   input  logic              req_valid,
   input  ebus_op_e          req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] lo_in,
   input  logic [DATA_W-1:0] rom_data,
   output logic              req_ready,
   output logic              act_q,
   output ebus_op_e          op_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic              ext_q,
   output logic              second_q,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data
);

   localparam logic [PW-1:0] READ_CAP = PW'(SLOT_CLKS - 2);

   logic hold_slot;
   logic cap_fetch;
   logic cap_read;
   logic take;

   assign hold_slot = act_q && op_is_data(op_q) && !second_q;
   assign req_ready = slot_end && !hold_slot;
   assign take      = req_ready && req_valid;
   assign cap_fetch = act_q && (op_q == OP_FETCH) && slot_end;
   assign cap_read  = act_q && second_q && op_is_data(op_q) &&
                      !op_is_write(op_q) && (phase == READ_CAP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q    <= 1'b0;
         op_q     <= OP_FETCH;
         addr_q   <= '0;
         wdata_q  <= '0;
         ext_q    <= 1'b0;
         second_q <= 1'b0;
      end else if (slot_end) begin
         if (hold_slot) begin
            second_q <= 1'b1;
         end else if (take) begin
            act_q    <= 1'b1;
            op_q     <= req_op;
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            ext_q    <= op_is_data(req_op) || !ea_n;
            second_q <= 1'b0;
         end else begin
            act_q    <= 1'b0;
            second_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= cap_fetch || cap_read;
         if (cap_fetch)     rsp_data <= ext_q ? lo_in : rom_data;
         else if (cap_read) rsp_data <= lo_in;
      end
   end

endmodule

// File: rtl/ebus_pin_mux.sv
`timescale 1ns/1ps
module ebus_pin_mux
   import ebus_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int SLOT_CLKS = 6,
   parameter int ALE_CLKS  = 2,
   localparam int PW   = $clog2(SLOT_CLKS),
   localparam int HI_W = ADDR_W - DATA_W
) (
   input  logic [PW-1:0]     phase,
   input  logic              act_q,
   input  ebus_op_e          op_q,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic [DATA_W-1:0] wdata_q,
   input  logic              ext_q,
   input  logic              second_q,
   input  logic [HI_W-1:0]   hi_sfr,
   output logic              ale,
   output logic              psen_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic [DATA_W-1:0] lo_out,
   output logic              lo_oe,
   output logic [HI_W-1:0]   hi_out
);

   localparam logic [PW-1:0] ALE_END   = PW'(ALE_CLKS);
   localparam logic [PW-1:0] STB_START = PW'(ALE_CLKS + 1);
   localparam logic [PW-1:0] STB_LAST  = PW'(SLOT_CLKS - 2);

   logic in_addr;
   logic is_data;
   logic is_wr;
   logic early_win;
   logic late_win;
   logic data_win;
   logic wdrive;

   assign is_data   = act_q && op_is_data(op_q);
   assign is_wr     = is_data && op_is_write(op_q);
   assign in_addr   = act_q && ext_q && !second_q && (phase < ALE_END);
   assign early_win = !second_q && (phase >= STB_START);
   assign late_win  = second_q && (phase <= STB_LAST);
   assign data_win  = early_win || late_win;
   assign wdrive    = is_wr && ((!second_q && (phase >= ALE_END)) || late_win);

   assign ale    = (phase < ALE_END) && !(is_data && second_q);
   assign psen_n = !(act_q && (op_q == OP_FETCH) && ext_q && early_win);
   assign rd_n   = !(is_data && !op_is_write(op_q) && data_win);
   assign wr_n   = !(is_wr && data_win);
   assign lo_oe  = in_addr || wdrive;
   assign lo_out = in_addr ? addr_q[DATA_W-1:0] : wdata_q;
   assign hi_out = (act_q && ext_q && !op_is_short(op_q)) ?
                   addr_q[ADDR_W-1:DATA_W] : hi_sfr;

endmodule

// File: rtl/ebus_seq.sv
`timescale 1ns/1ps
module ebus_seq
   import ebus_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int SLOT_CLKS = 6,
   parameter int ALE_CLKS  = 2,
   localparam int HI_W = ADDR_W - DATA_W,
   localparam int PW   = $clog2(SLOT_CLKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ea_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   input  logic [HI_W-1:0]   hi_sfr,
   output logic              ale,
   output logic              psen_n,
   output logic              rd_n,
   output logic              wr_n,
   output logic [DATA_W-1:0] lo_out,
   output logic              lo_oe,
   input  logic [DATA_W-1:0] lo_in,
   output logic [HI_W-1:0]   hi_out,
   output logic [ADDR_W-1:0] rom_addr,
   input  logic [DATA_W-1:0] rom_data
);

   if (ADDR_W <= DATA_W) begin : g_bad_width
      $error("ADDR_W must exceed DATA_W");
   end
   if (ALE_CLKS < 1) begin : g_bad_ale
      $error("ALE_CLKS must be at least 1");
   end
   if (SLOT_CLKS < ALE_CLKS + 3) begin : g_bad_slot
      $error("SLOT_CLKS too short for strobe window");
   end

   logic [PW-1:0]     phase;
   logic              slot_end;
   logic              act_q;
   ebus_op_e          op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              ext_q;
   logic              second_q;

   ebus_slot_timer #(.SLOT_CLKS(SLOT_CLKS)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase    (phase),
      .slot_end (slot_end)
   );

   ebus_xfer_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_CLKS(SLOT_CLKS)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase     (phase),
      .slot_end  (slot_end),
      .ea_n      (ea_n),
      .req_valid (req_valid),
      .req_op    (ebus_op_e'(req_op)),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .lo_in     (lo_in),
      .rom_data  (rom_data),
      .req_ready (req_ready),
      .act_q     (act_q),
      .op_q      (op_q),
      .addr_q    (addr_q),
      .wdata_q   (wdata_q),
      .ext_q     (ext_q),
      .second_q  (second_q),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data)
   );

   ebus_pin_mux #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .SLOT_CLKS(SLOT_CLKS), .ALE_CLKS(ALE_CLKS)
   ) u_pins (
      .phase    (phase),
      .act_q    (act_q),
      .op_q     (op_q),
      .addr_q   (addr_q),
      .wdata_q  (wdata_q),
      .ext_q    (ext_q),
      .second_q (second_q),
      .hi_sfr   (hi_sfr),
      .ale      (ale),
      .psen_n   (psen_n),
      .rd_n     (rd_n),
      .wr_n     (wr_n),
      .lo_out   (lo_out),
      .lo_oe    (lo_oe),
      .hi_out   (hi_out)
   );

   assign rom_addr = addr_q;

endmodule

// File: rtl/ebus_seq_chk.sv
`timescale 1ns/1ps
module ebus_seq_chk #(
   parameter int ALE_CLKS = 2
) (
   input logic clk,
   input logic rst_n,
   input logic ale,
   input logic psen_n,
   input logic rd_n,
   input logic wr_n,
   input logic lo_oe,
   input logic rsp_valid
);

   logic [7:0] ale_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ale_run <= '0;
      else if (!ale)             ale_run <= '0;
      else if (ale_run != 8'hFF) ale_run <= ale_run + 1'b1;
   end

   assert_ale_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (ale_run < 8'(ALE_CLKS)));

   assert_ale_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ale |-> (psen_n && rd_n && wr_n));

   assert_write_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> lo_oe);

   assert_read_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !lo_oe);

   assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

endmodule

bind ebus_seq ebus_seq_chk #(.ALE_CLKS(ALE_CLKS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ale       (ale),
   .psen_n    (psen_n),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .lo_oe     (lo_oe),
   .rsp_valid (rsp_valid)
);

// File: tb/sim_ebus_seq.sv
`timescale 1ns/1ps
module sim_ebus_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ea_n = 1'b1;
   logic        req_valid = 1'b0;
   logic [2:0]  req_op = 3'd0;
   logic [15:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready;
   logic        rsp_valid;
   logic [7:0]  rsp_data;
   logic [7:0]  hi_sfr = 8'h00;
   logic        ale, psen_n, rd_n, wr_n, lo_oe;
   logic [7:0]  lo_out, lo_in, hi_out, rom_data;
   logic [15:0] rom_addr;

   always #2 clk = ~clk;

   ebus_seq u0 (
      .clk(clk), .rst_n(rst_n), .ea_n(ea_n),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .hi_sfr(hi_sfr),
      .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
      .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in), .hi_out(hi_out),
      .rom_addr(rom_addr), .rom_data(rom_data)
   );

   // external memory model
   logic [7:0] dmem   [256];
   logic [7:0] shadow [256];
   logic [7:0] lat_lo = 8'h00;

   function automatic logic [7:0] code_byte(logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h3C;
   endfunction

   assign rom_data = rom_addr[7:0] + 8'h11;
   assign lo_in = !psen_n ? code_byte({hi_out, lat_lo}) :
                  (!rd_n ? dmem[lat_lo] : 8'hFF);

   typedef struct { logic [7:0] data; int lat; } rsp_t;
   typedef struct { logic [7:0] hi; logic [7:0] lo; logic [7:0] wd; bit wr; } pin_t;

   rsp_t rsp_q[$];
   pin_t pin_q[$];
   int   acc_q[$];

   int cyc = 0;
   int n_chk = 0;
   int n_fail = 0;
   int psen_lows = 0;
   int oe_highs = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor / scoreboard
   bit         strobe_prev = 0;
   bit         wr_prev = 0;
   int         wr_len = 0;
   logic [7:0] wr_byte = 8'h00;

   always begin
      bit   strobe;
      pin_t p;
      rsp_t r;
      int   a;
      @(negedge clk);
      #1;
      if (rst_n) begin
         if (!psen_n) psen_lows++;
         if (lo_oe)   oe_highs++;
         if (req_valid && req_ready && req_op != 3'd2 && req_op != 3'd4)
            acc_q.push_back(cyc + 1);
         strobe = !psen_n || !rd_n || !wr_n;
         if (strobe && !strobe_prev) begin
            if (pin_q.size() == 0) chk(0, "R8 unexpected bus strobe", 1, 0);
            else begin
               p = pin_q.pop_front();
               chk(hi_out == p.hi, "R6/R7 high port", hi_out, p.hi);
               chk(lat_lo == p.lo, "R3 latched low address", lat_lo, p.lo);
               if (p.wr) begin
                  chk(lo_oe == 1'b1, "R4 write drive enable", lo_oe, 1);
                  chk(lo_out == p.wd, "R4 write byte", lo_out, p.wd);
               end else begin
                  chk(lo_oe == 1'b0, "R5 low port released in read", lo_oe, 0);
               end
            end
         end
         if (!wr_n) begin
            wr_len++;
            wr_byte = lo_out;
         end else if (wr_prev) begin
            chk(wr_len == 8, "R4 write strobe width", wr_len, 8);
            dmem[lat_lo] = wr_byte;
            wr_len = 0;
         end
         if (rsp_valid) begin
            if (rsp_q.size() == 0 || acc_q.size() == 0)
               chk(0, "R5 unexpected response", rsp_data, 0);
            else begin
               r = rsp_q.pop_front();
               a = acc_q.pop_front();
               chk(rsp_data == r.data, "R5 returned byte", rsp_data, r.data);
               chk(cyc - a == r.lat, "R5 response latency", cyc - a, r.lat);
            end
         end
         if (ale && lo_oe) lat_lo = lo_out;
         strobe_prev = strobe;
         wr_prev = !wr_n;
      end
   end

   // driver
   task automatic issue(logic [2:0] op, logic [15:0] a, logic [7:0] wd);
      pin_t p;
      rsp_t r;
      bit   is_data, is_wr, is_short, ext;
      is_data  = (op != 3'd0);
      is_wr    = (op == 3'd2) || (op == 3'd4);
      is_short = (op == 3'd3) || (op == 3'd4);
      ext      = is_data || !ea_n;
      @(negedge clk);
      if (ext) begin
         p.hi = is_short ? hi_sfr : a[15:8];
         p.lo = a[7:0];
         p.wd = wd;
         p.wr = is_wr;
         pin_q.push_back(p);
      end
      if (!is_wr) begin
         if (!is_data) begin
            r.data = ext ? code_byte(a) : (a[7:0] + 8'h11);
            r.lat  = 6;
         end else begin
            r.data = shadow[a[7:0]];
            r.lat  = 11;
         end
         rsp_q.push_back(r);
      end else begin
         shadow[a[7:0]] = wd;
      end
      req_valid = 1'b1;
      req_op    = op;
      req_addr  = a;
      req_wdata = wd;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic align_ale();
      logic pv;
      pv = ale;
      @(negedge clk);
      while (!(ale && !pv)) begin
         pv = ale;
         @(negedge clk);
      end
   endtask

   task automatic count_rest(input int n, output int pulses);
      logic pv;
      pulses = 1;
      pv = 1'b1;
      for (int i = 1; i < n; i++) begin
         @(negedge clk);
         if (ale && !pv) pulses++;
         pv = ale;
      end
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int pulses, ps0, oe0;
      for (int i = 0; i < 256; i++) begin
         dmem[i]   = 8'(i) ^ 8'hA5;
         shadow[i] = 8'(i) ^ 8'hA5;
      end
      repeat (5) @(posedge clk);
      @(negedge clk);
      // reset state
      chk(psen_n && rd_n && wr_n, "R9 strobes idle in reset", {psen_n, rd_n, wr_n}, 3'b111);
      chk(!lo_oe, "R3 low port released in reset", lo_oe, 0);
      chk(!rsp_valid, "R5 no response in reset", rsp_valid, 0);
      rst_n = 1'b1;

      // idle pulse rate
      repeat (3) @(negedge clk);
      oe0 = oe_highs;
      align_ale();
      count_rest(60, pulses);
      chk(pulses == 10, "R1 idle pulse count", pulses, 10);
      chk(oe_highs == oe0, "R3 idle low port released", oe_highs - oe0, 0);

      // internal fetches
      ea_n = 1'b1;
      ps0 = psen_lows;
      oe0 = oe_highs;
      issue(3'd0, 16'h1234, 8'h00);
      issue(3'd0, 16'hFFFF, 8'h00);
      issue(3'd0, 16'h0000, 8'h00);
      repeat (12) @(negedge clk);
      chk(psen_lows == ps0, "R8 internal fetch keeps psen_n high", psen_lows - ps0, 0);
      chk(oe_highs == oe0, "R8 internal fetch keeps low port released", oe_highs - oe0, 0);

      // external fetches
      ea_n = 1'b0;
      issue(3'd0, 16'h0000, 8'h00);
      issue(3'd0, 16'hFFFF, 8'h00);
      issue(3'd0, 16'hA55A, 8'h00);
      repeat (12) @(negedge clk);

      // data writes and reads, both addressing modes
      ps0 = psen_lows;
      hi_sfr = 8'h3C;
      issue(3'd2, 16'h1280, 8'h77);
      issue(3'd4, 16'h0081, 8'h99);
      issue(3'd1, 16'h5580, 8'h00);
      hi_sfr = 8'hC3;
      issue(3'd3, 16'h0081, 8'h00);
      repeat (14) @(negedge clk);
      chk(psen_lows == ps0, "R9 data accesses keep psen_n high", psen_lows - ps0, 0);

      // ready timing
      issue(3'd1, 16'h4402, 8'h00);
      repeat (5) @(negedge clk);
      chk(!req_ready, "R10 ready low in first data slot", req_ready, 0);
      repeat (6) @(negedge clk);
      chk(req_ready, "R10 ready at end of second slot", req_ready, 1);
      repeat (14) @(negedge clk);

      // pulse suppression window with mixed traffic
      align_ale();
      fork
         count_rest(360, pulses);
         begin
            issue(3'd2, 16'hBE10, 8'h5E);
            issue(3'd1, 16'hBE10, 8'h00);
            issue(3'd0, 16'h7701, 8'h00);
            hi_sfr = 8'h81;
            issue(3'd4, 16'h0011, 8'hE7);
            issue(3'd3, 16'h0011, 8'h00);
            ea_n = 1'b1;
            issue(3'd0, 16'h2002, 8'h00);
         end
      join
      chk(pulses == 56, "R2 one pulse skipped per data access", pulses, 56);

      repeat (30) @(negedge clk);
      chk(rsp_q.size() == 0, "R5 all responses returned", rsp_q.size(), 0);
      chk(pin_q.size() == 0, "R6 all external accesses strobed", pin_q.size(), 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule